// File: doc/BRIEF.md
# Start-up Delay and Restart-Cause Sequencer

This block decides when a small processor core may run after power-on, after its external reset pin is pulled, after a watchdog expiry, or when it wakes from sleep. After power-on it runs a power-up timer and then an oscillator start-up counter before it releases the internal reset. Which of the two delays run depends on the selected oscillator mode and on whether the power-up timer is enabled. The delays are timed from the power-on pulse itself and not from the external pin, so a board that holds the pin low past the delays starts the core in the same cycle the pin rises.

The block also keeps two status flags, time-out and power-down. Software reads them after a restart to tell a power-on, a watchdog reset, a watchdog wake-up and an external reset apart. Sleep entry, the watchdog-clear command and each restart cause write these flags. The watchdog, the oscillator and the CPU are outside the block. It sees them only as single-cycle event inputs and a mode selection, all synchronous to the oscillator clock.

Top module: `startupSequencer`

## Requirements
- R1: While `porPulse` is high, `coreReset` is 1, `runEnable` is 0, and `toFlag` and `pdFlag` are both 1.
- R2: `oscMode` codes 0, 1 and 2 are crystal modes and code 3 is RC. After `porPulse` falls with `extResetN` high, `coreReset` stays high for 1 + (`pwrtEnable` ? PWRT_CYCLES : 0) + (crystal ? OST_CYCLES : 0) rising clock edges. The power-up timer runs before the start-up counter. `runEnable` then goes to 1.
- R3: In RC mode (code 3) the start-up counter is skipped. In RC mode with the power-up timer disabled, `coreReset` falls after a single edge.
- R4: If `extResetN` is held low past the start-up delays, `coreReset` falls and `runEnable` rises in the same cycle the pin goes high, with no further delay.
- R5: While running, a low `extResetN` forces `coreReset` to 1 and `runEnable` to 0. The flags do not change, and sleep and watchdog events are ignored while the pin is low.
- R6: A `sleepEnter` pulse while running enters sleep: `runEnable` becomes 0, `coreReset` stays 0, and the flags become TO=1, PD=0.
- R7: A `wakeEvent` pulse in sleep resumes execution without asserting `coreReset`. In crystal modes `runEnable` rises 1 + OST_CYCLES edges after the pulse, with no power-up timer. In RC mode it rises after 1 edge. The flags stay TO=1, PD=0.
- R8: A `wdtTimeout` pulse while running sets TO=0, PD=1, asserts `coreReset` and reruns the full start-up chain of R2. It takes precedence over a `sleepEnter` in the same cycle.
- R9: A `wdtTimeout` pulse in sleep sets TO=0, PD=0 and wakes the core as in R7, without `coreReset`.
- R10: A low `extResetN` during sleep sets TO=1, PD=0 and leaves sleep. `coreReset` stays high until the pin rises, and `runEnable` rises in that same cycle.
- R11: A `wdtClear` pulse while running sets both TO and PD to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porPulse | input | 1 | Power-on reset pulse, active high, asynchronous assert |
| extResetN | input | 1 | External reset pin, active low |
| wdtTimeout | input | 1 | Watchdog expiry event, one cycle |
| sleepEnter | input | 1 | Sleep-entry command, one cycle |
| wakeEvent | input | 1 | Interrupt wake-up event, one cycle |
| wdtClear | input | 1 | Watchdog-clear command, one cycle |
| oscMode | input | 2 | Oscillator mode: 0..2 crystal, 3 RC |
| pwrtEnable | input | 1 | Power-up timer enable |
| coreReset | output | 1 | Internal reset to the core, active high |
| runEnable | output | 1 | Core may execute |
| toFlag | output | 1 | Time-out status flag |
| pdFlag | output | 1 | Power-down status flag |

## Verification
The bench builds the block with PWRT_CYCLES = 40 and OST_CYCLES = 16 instead of the real-time defaults. With these short values every combination of oscillator mode and timer enable can be timed edge by edge, and the delay is counted exactly in each case. The different lengths of the two delays also expose a swapped or missing stage in the count. Short delays also leave room for random sequences of sleep, wake, watchdog and pin events after each power-on, with the flags tracked by a bench model.

// File: rtl/startupPkg.sv
`timescale 1ns/1ps
package startupPkg;
  typedef enum logic [1:0] {
    OSC_LP = 2'd0,
    OSC_XT = 2'd1,
    OSC_HS = 2'd2,
    OSC_RC = 2'd3
  } oscModeT;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_PWRT,
    ST_OST,
    ST_RUN,
    ST_SLEEP
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPwrt;
    logic loadOst;
    logic decCount;
    logic writeFlags;
    logic newTo;
    logic newPd;
  } seqStrobeT;
endpackage

// File: rtl/startupDatapath.sv
`timescale 1ns/1ps
module startupDatapath
  import startupPkg::*;
#(
  parameter int PWRT_CYCLES = 3_600_000,
  parameter int OST_CYCLES  = 1024
) (
  input  logic      clk,
  input  logic      porPulse,
  input  seqStrobeT strobe,
  output logic      countZero,
  output logic      toFlag,
  output logic      pdFlag
);
  localparam int MAX_LOAD = (PWRT_CYCLES > OST_CYCLES) ? PWRT_CYCLES : OST_CYCLES;
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);
  localparam logic [CNT_W-1:0] PWRT_LOAD = CNT_W'(PWRT_CYCLES - 1);
  localparam logic [CNT_W-1:0] OST_LOAD  = CNT_W'(OST_CYCLES - 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse) begin
      count <= '0;
    end else if (strobe.loadPwrt) begin
      count <= PWRT_LOAD;
    end else if (strobe.loadOst) begin
      count <= OST_LOAD;
    end else if (strobe.decCount) begin
      count <= count - 1'b1;
    end
  end

  assign countZero = (count == '0);

  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse) begin
      toFlag <= 1'b1;
      pdFlag <= 1'b1;
    end else if (strobe.writeFlags) begin
      toFlag <= strobe.newTo;
      pdFlag <= strobe.newPd;
    end
  end
endmodule

// File: rtl/startupControl.sv
`timescale 1ns/1ps
module startupControl
  import startupPkg::*;
(
  input  logic       clk,
  input  logic       porPulse,
  input  logic       extResetN,
  input  logic       wdtTimeout,
  input  logic       sleepEnter,
  input  logic       wakeEvent,
  input  logic       wdtClear,
  input  logic [1:0] oscMode,
  input  logic       pwrtEnable,
  input  logic       countZero,
  output seqStrobeT  strobe,
  output logic       coreReset,
  output logic       runEnable
);
  seqStateT state, nextState;
  logic     wakeDelay, nextWake;
  logic     crystal;

  assign crystal = (oscModeT'(oscMode) != OSC_RC);

  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse) begin
      state     <= ST_BOOT;
      wakeDelay <= 1'b0;
    end else begin
      state     <= nextState;
      wakeDelay <= nextWake;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextWake  = wakeDelay;
    case (state)
      ST_BOOT: begin
        nextWake = 1'b0;
        if (pwrtEnable) begin
          strobe.loadPwrt = 1'b1;
          nextState       = ST_PWRT;
        end else if (crystal) begin
          strobe.loadOst = 1'b1;
          nextState      = ST_OST;
        end else begin
          nextState = ST_RUN;
        end
      end
      ST_PWRT: begin
        if (!countZero) begin
          strobe.decCount = 1'b1;
        end else if (crystal) begin
          strobe.loadOst = 1'b1;
          nextState      = ST_OST;
        end else begin
          nextState = ST_RUN;
        end
      end
      ST_OST: begin
        if (wakeDelay && !extResetN) begin
          strobe.writeFlags = 1'b1;
          strobe.newTo      = 1'b1;
          strobe.newPd      = 1'b0;
          nextState         = ST_RUN;
          nextWake          = 1'b0;
        end else if (!countZero) begin
          strobe.decCount = 1'b1;
        end else begin
          nextState = ST_RUN;
          nextWake  = 1'b0;
        end
      end
      ST_RUN: begin
        if (extResetN) begin
          if (wdtTimeout) begin
            strobe.writeFlags = 1'b1;
            strobe.newTo      = 1'b0;
            strobe.newPd      = 1'b1;
            nextState         = ST_BOOT;
          end else if (sleepEnter) begin
            strobe.writeFlags = 1'b1;
            strobe.newTo      = 1'b1;
            strobe.newPd      = 1'b0;
            nextState         = ST_SLEEP;
          end else if (wdtClear) begin
            strobe.writeFlags = 1'b1;
            strobe.newTo      = 1'b1;
            strobe.newPd      = 1'b1;
          end
        end
      end
      ST_SLEEP: begin
        if (!extResetN) begin
          strobe.writeFlags = 1'b1;
          strobe.newTo      = 1'b1;
          strobe.newPd      = 1'b0;
          nextState         = ST_RUN;
        end else if (wdtTimeout || wakeEvent) begin
          if (wdtTimeout) begin
            strobe.writeFlags = 1'b1;
            strobe.newTo      = 1'b0;
            strobe.newPd      = 1'b0;
          end
          if (crystal) begin
            strobe.loadOst = 1'b1;
            nextState      = ST_OST;
            nextWake       = 1'b1;
          end else begin
            nextState = ST_RUN;
          end
        end
      end
      default: nextState = ST_BOOT;
    endcase
  end

  assign coreReset = (state == ST_BOOT) || (state == ST_PWRT) ||
                     ((state == ST_OST) && !wakeDelay) || !extResetN;
  assign runEnable = (state == ST_RUN) && extResetN;
endmodule

// File: rtl/startupSequencer.sv
`timescale 1ns/1ps
module startupSequencer
  import startupPkg::*;
#(
  parameter int PWRT_CYCLES = 3_600_000,
  parameter int OST_CYCLES  = 1024
) (
  input  logic       clk,
  input  logic       porPulse,
  input  logic       extResetN,
  input  logic       wdtTimeout,
  input  logic       sleepEnter,
  input  logic       wakeEvent,
  input  logic       wdtClear,
  input  logic [1:0] oscMode,
  input  logic       pwrtEnable,
  output logic       coreReset,
  output logic       runEnable,
  output logic       toFlag,
  output logic       pdFlag
);
  seqStrobeT strobe;
  logic      countZero;

  startupControl uCtrl (
    .clk        (clk),
    .porPulse   (porPulse),
    .extResetN  (extResetN),
    .wdtTimeout (wdtTimeout),
    .sleepEnter (sleepEnter),
    .wakeEvent  (wakeEvent),
    .wdtClear   (wdtClear),
    .oscMode    (oscMode),
    .pwrtEnable (pwrtEnable),
    .countZero  (countZero),
    .strobe     (strobe),
    .coreReset  (coreReset),
    .runEnable  (runEnable)
  );

  startupDatapath #(
    .PWRT_CYCLES (PWRT_CYCLES),
    .OST_CYCLES  (OST_CYCLES)
  ) uPath (
    .clk       (clk),
    .porPulse  (porPulse),
    .strobe    (strobe),
    .countZero (countZero),
    .toFlag    (toFlag),
    .pdFlag    (pdFlag)
  );
endmodule

// File: rtl/startupChecker.sv
`timescale 1ns/1ps
module startupChecker (
  input logic clk,
  input logic porPulse,
  input logic extResetN,
  input logic wdtTimeout,
  input logic sleepEnter,
  input logic wdtClear,
  input logic coreReset,
  input logic runEnable,
  input logic toFlag,
  input logic pdFlag
);
  // R1: power-on pulse holds reset and sets both flags
  always @(posedge clk) begin
    if (porPulse) begin
      p_por_state_r1: assert (coreReset && !runEnable && toFlag && pdFlag)
        else $error("p_por_state_r1");
    end
  end

  p_pin_low_r5: assert property (@(posedge clk) disable iff (porPulse)
    !extResetN |-> (coreReset && !runEnable));

  p_sleep_entry_r6: assert property (@(posedge clk) disable iff (porPulse)
    (runEnable && sleepEnter && !wdtTimeout) |=>
      (toFlag && !pdFlag && !runEnable && !coreReset));

  p_wake_no_reset_r7: assert property (@(posedge clk) disable iff (porPulse)
    (!coreReset && !runEnable && extResetN) |=> (!extResetN || !coreReset));

  p_wdt_reset_r8: assert property (@(posedge clk) disable iff (porPulse)
    (runEnable && wdtTimeout) |=> (!toFlag && pdFlag && coreReset));

  p_clear_flags_r11: assert property (@(posedge clk) disable iff (porPulse)
    (runEnable && wdtClear && !wdtTimeout && !sleepEnter) |=> (toFlag && pdFlag));
endmodule

bind startupSequencer startupChecker uChk (
  .clk        (clk),
  .porPulse   (porPulse),
  .extResetN  (extResetN),
  .wdtTimeout (wdtTimeout),
  .sleepEnter (sleepEnter),
  .wdtClear   (wdtClear),
  .coreReset  (coreReset),
  .runEnable  (runEnable),
  .toFlag     (toFlag),
  .pdFlag     (pdFlag)
);

// File: tb/startupSequencer_test.sv
`timescale 1ns/1ps
module startupSequencer_test;
  localparam int P = 40;
  localparam int O = 16;

  logic clk = 1'b0;
  logic porPulse = 1'b0;
  logic extResetN = 1'b1;
  logic wdtTimeout = 1'b0;
  logic sleepEnter = 1'b0;
  logic wakeEvent = 1'b0;
  logic wdtClear = 1'b0;
  logic [1:0] oscMode = 2'd1;
  logic pwrtEnable = 1'b1;
  logic coreReset, runEnable, toFlag, pdFlag;

  int passCnt = 0;
  int failCnt = 0;
  int expFlags = 3;   // {TO,PD} model
  bit finished = 1'b0;

  always #10 clk = ~clk;

  startupSequencer #(.PWRT_CYCLES(P), .OST_CYCLES(O)) uut (
    .clk(clk), .porPulse(porPulse), .extResetN(extResetN),
    .wdtTimeout(wdtTimeout), .sleepEnter(sleepEnter), .wakeEvent(wakeEvent),
    .wdtClear(wdtClear), .oscMode(oscMode), .pwrtEnable(pwrtEnable),
    .coreReset(coreReset), .runEnable(runEnable), .toFlag(toFlag), .pdFlag(pdFlag)
  );

  function automatic int expBoot(int mode, bit pwrt);
    return 1 + (pwrt ? P : 0) + ((mode != 3) ? O : 0);
  endfunction

  function automatic int expWake(int mode);
    return 1 + ((mode != 3) ? O : 0);
  endfunction

  function automatic int flags();
    return {toFlag, pdFlag};
  endfunction

  task automatic chk(string tag, int act, int exp);
    if (act == exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runPor(int mode, bit pwrt);
    int n;
    @(negedge clk);
    oscMode = 2'(mode); pwrtEnable = pwrt; extResetN = 1'b1; porPulse = 1'b1;
    @(negedge clk);
    chk("R1 reset/run", {coreReset, runEnable}, 2);
    chk("R1 flags", flags(), 3);
    porPulse = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (coreReset && n < 5000);
    chk((mode == 3) ? "R3 boot delay" : "R2 boot delay", n, expBoot(mode, pwrt));
    chk("R2 run after boot", runEnable, 1);
    expFlags = 3;
  endtask

  task automatic doSleep();
    @(negedge clk); sleepEnter = 1'b1;
    @(negedge clk); sleepEnter = 1'b0;
    chk("R6 reset/run in sleep", {coreReset, runEnable}, 0);
    chk("R6 flags", flags(), 2);
    expFlags = 2;
  endtask

  task automatic doWake(int mode, bit viaWdt);
    int n; bit sawReset;
    @(negedge clk);
    if (viaWdt) wdtTimeout = 1'b1; else wakeEvent = 1'b1;
    n = 0; sawReset = 1'b0;
    do begin
      @(negedge clk);
      wdtTimeout = 1'b0; wakeEvent = 1'b0;
      n++;
      if (coreReset) sawReset = 1'b1;
    end while (!runEnable && n < 5000);
    chk(viaWdt ? "R9 wake delay" : "R7 wake delay", n, expWake(mode));
    chk("R7 no reset on wake", sawReset, 0);
    chk(viaWdt ? "R9 flags" : "R7 flags", flags(), viaWdt ? 0 : 2);
    expFlags = viaWdt ? 0 : 2;
  endtask

  task automatic doWdtReset(int mode, bit pwrt, bit withSleep);
    int n;
    @(negedge clk); wdtTimeout = 1'b1; sleepEnter = withSleep;
    @(negedge clk); wdtTimeout = 1'b0; sleepEnter = 1'b0;
    chk("R8 flags", flags(), 1);
    chk("R8 reset asserted", coreReset, 1);
    n = 1;
    while (coreReset && n < 5000) begin @(negedge clk); n++; end
    chk("R8 rerun delay", n, 1 + expBoot(mode, pwrt));
    expFlags = 1;
  endtask

  task automatic doClear();
    @(negedge clk); wdtClear = 1'b1;
    @(negedge clk); wdtClear = 1'b0;
    chk("R11 flags", flags(), 3);
    expFlags = 3;
  endtask

  task automatic doExtRun();
    @(negedge clk); extResetN = 1'b0;
    #1 chk("R5 pin low reset/run", {coreReset, runEnable}, 2);
    @(negedge clk); sleepEnter = 1'b1; wdtTimeout = 1'b1;
    @(negedge clk); sleepEnter = 1'b0; wdtTimeout = 1'b0;
    @(negedge clk);
    chk("R5 flags unchanged", flags(), expFlags);
    extResetN = 1'b1;
    #1 chk("R5 run after pin", {coreReset, runEnable}, 1);
    @(negedge clk);
    chk("R5 events ignored", runEnable, 1);
  endtask

  task automatic doExtSleep();
    doSleep();
    @(negedge clk); extResetN = 1'b0;
    @(negedge clk);
    chk("R10 flags", flags(), 2);
    chk("R10 reset held", coreReset, 1);
    repeat (3) @(negedge clk);
    chk("R10 still held", {coreReset, runEnable}, 2);
    extResetN = 1'b1;
    #1 chk("R10 run on release", {coreReset, runEnable}, 1);
    expFlags = 2;
  endtask

  task automatic extHold(int mode, bit pwrt);
    @(negedge clk);
    oscMode = 2'(mode); pwrtEnable = pwrt; porPulse = 1'b1; extResetN = 1'b0;
    @(negedge clk); porPulse = 1'b0;
    repeat (expBoot(mode, pwrt) + 5) @(negedge clk);
    chk("R4 held by pin", coreReset, 1);
    extResetN = 1'b1;
    #1 chk("R4 immediate start", {coreReset, runEnable}, 1);
    chk("R4 flags", flags(), 3);
    expFlags = 3;
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'd4242);
    #1 porPulse = 1'b1;
    // directed corners
    runPor(1, 1'b1);
    runPor(3, 1'b1);
    runPor(3, 1'b0);          // R3 single edge
    runPor(2, 1'b0);
    extHold(0, 1'b1);
    extHold(3, 1'b0);
    runPor(0, 1'b1);
    doSleep(); doWake(0, 1'b0);
    doSleep(); doWake(0, 1'b1);
    doWdtReset(0, 1'b1, 1'b1); // R8 precedence over sleep
    doClear();
    doExtRun();
    doExtSleep();
    runPor(3, 1'b0);
    doSleep(); doWake(3, 1'b0);
    doSleep(); doWake(3, 1'b1);
    // constrained random
    for (int it = 0; it < 10; it++) begin
      int mode; bit pwrt;
      mode = int'($urandom % 4);
      pwrt = 1'($urandom % 2);
      runPor(mode, pwrt);
      for (int k = 0; k < 5; k++) begin
        case ($urandom % 6)
          0: begin doSleep(); doWake(mode, 1'b0); end
          1: begin doSleep(); doWake(mode, 1'b1); end
          2: doWdtReset(mode, pwrt, 1'($urandom % 2));
          3: doClear();
          4: doExtRun();
          default: doExtSleep();
        endcase
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

  initial begin
    #3_000_000;
    if (!finished) begin
      finished = 1'b1;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end
endmodule